// File: doc/BRIEF.md
# Stack Push Sequencer

This block is a small non-pipelined datapath with its own control sequencer. It executes one operation: pushing the contents of one of two 8-bit data registers onto a descending stack held in external memory. A one-cycle start strobe, with a one-bit select, picks the source register. The sequencer copies the stack pointer into a 16-bit address register. At the same time it copies the selected register into an 8-bit data register.

The block then holds a synchronous write to memory for two clock cycles, driven from those two registers. In a third, separate cycle the stack pointer counts itself down by one. This decrement uses only the pointer's own logic and no arithmetic path. A one-cycle done pulse follows.

The two data registers are loaded through a plain write port. The current stack pointer is visible on an output, so the caller can follow the stack depth.

Top module: `stack_push_unit`

## Requirements
- R1: After reset the stack pointer reads the reset value (parameter, default 0xFFFF), done is 0, memory write enable is 0, and both data registers hold 0x00.
- R2: A start accepted with `src_sel`=0 writes register A, and with `src_sel`=1 writes register B, to memory.
- R3: The memory write enable is high for exactly two consecutive cycles per push. Address and write data stay stable throughout those cycles.
- R4: The write address is the stack pointer value held when the start was accepted, before any decrement.
- R5: After the write, the stack pointer decreases by exactly one. A decrement from 0x0000 gives 0xFFFF.
- R6: A push takes three cycles after the accepting edge: two write cycles, then one decrement cycle. `done` is high for exactly one cycle after that, and the new stack pointer is already visible in that cycle.
- R7: A start strobe raised while a push is in progress is ignored: there is no extra write, no extra decrement and no extra done.
- R8: Changing `src_sel`, or loading the data registers, while a push is in progress does not change the byte being written. A register load takes effect for the next push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Push request strobe, accepted only when idle |
| src_sel | input | 1 | Source register select: 0 = A, 1 = B |
| ld_en | input | 1 | Load enable for a data register |
| ld_sel | input | 1 | Register to load: 0 = A, 1 = B |
| ld_data | input | 8 | Value to load |
| done | output | 1 | One-cycle push-complete pulse |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address, from the address register |
| mem_wdata | output | 8 | Memory write data, from the data register |
| sp_value | output | 16 | Current stack pointer |

## Verification
A sequencer stuck in the wrong state shows up within one or two cycles of a start. The sign is a write-enable run other than two cycles long, or a done that is late, missing or doubled. An address or data register captured at the wrong moment shows up in the byte stored by the bench memory, or in the address it lands at. This is caught when the push completes. A wrong stack pointer, whether from a missed decrement, a double decrement or a failed wrap, appears directly on the pointer output in the done cycle. It also appears as a misplaced write on the next push.

// File: rtl/stack_push_pkg.sv
// Package: shared types for the stack push sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package stack_push_pkg;

    // Sequencer phases: idle, memory write (multi-cycle), local decrement.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_DEC   = 2'd2
    } push_phase_t;

endpackage

// File: rtl/push_data_regs.sv
// Module: push_data_regs
// Holds the two data registers and the 2:1 source multiplexer feeding
// the internal data bus. Assumes loads are synchronous and one at a time.
module push_data_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              src_sel,
    output logic [DATA_W-1:0] bus_data
);

    localparam int NREG = 2;

    logic [DATA_W-1:0] regs_q [NREG];

    // One storage register per source, each with its own load decode.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (ld_en && (int'(ld_sel) == g)) begin
                regs_q[g] <= ld_data;
            end
        end
    end

    // Source multiplexer onto the data bus.
    always_comb begin
        bus_data = src_sel ? regs_q[1] : regs_q[0];
    end

endmodule

// File: rtl/push_stack_ptr.sv
// Module: push_stack_ptr
// Stack pointer with its own down-counter; never uses an arithmetic unit
// shared with data. Assumes dec_en is a single-cycle request.
module push_stack_ptr #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    output logic [ADDR_W-1:0] sp
);

    logic [ADDR_W-1:0] sp_q;

    // Reset to the configured top, count down by one on request (wraps).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_RESET;
        end else if (dec_en) begin
            sp_q <= sp_q - ADDR_W'(1);
        end
    end

    assign sp = sp_q;

    // R5: a decrement request lowers the pointer by exactly one, modulo width.
    a_r5_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> (sp_q == $past(sp_q) - ADDR_W'(1)));

    // R5: without a request the pointer holds.
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> $stable(sp_q));

endmodule

// File: rtl/push_bus_regs.sv
// Module: push_bus_regs
// Memory address and memory data registers. Both capture on the accept
// strobe and hold until the next accept, so the memory sees stable values.
module push_bus_regs #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              we,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr
);

    // Capture address and data together when a push is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
            mdr <= '0;
        end else if (capture) begin
            mar <= sp_in;
            mdr <= bus_in;
        end
    end

    // R3: address and data hold across consecutive write cycles.
    a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $past(we)) |-> ($stable(mar) && $stable(mdr)));

endmodule

// File: rtl/push_sequencer.sv
// Module: push_sequencer
// Control FSM: accepts a start only when idle, holds the write for
// MEM_CYC cycles, issues one decrement cycle, then pulses done.
module push_sequencer
    import stack_push_pkg::*;
#(
    parameter int MEM_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic capture,
    output logic mem_we,
    output logic dec_en,
    output logic done
);

    localparam int CNT_W = (MEM_CYC > 1) ? $clog2(MEM_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MEM_CYC - 1);

    push_phase_t       phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;

    // Next-phase decode and per-phase control strobes.
    always_comb begin
        phase_d = phase_q;
        capture = 1'b0;
        mem_we  = 1'b0;
        dec_en  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    capture = 1'b1;
                    phase_d = PH_WRITE;
                end
            end
            PH_WRITE: begin
                mem_we = 1'b1;
                if (cnt_q == CNT_LAST) phase_d = PH_DEC;
            end
            PH_DEC: begin
                dec_en  = 1'b1;
                phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Write-cycle counter, cleared outside the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_q != PH_WRITE) cnt_q <= '0;
        else                               cnt_q <= cnt_q + CNT_W'(1);
    end

    // Done pulse in the cycle after the decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (phase_q == PH_DEC);
    end

    assign done = done_q;

    // R6: the write phase is only left for the decrement phase.
    a_r6_write_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WRITE) |=> (phase_q == PH_WRITE || phase_q == PH_DEC));

    // R6: done lasts a single cycle.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7: a start during an active push never recaptures the bus registers.
    a_r7_no_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |-> !capture);

endmodule

// File: rtl/stack_push_unit.sv
// Module: stack_push_unit (top)
// Non-pipelined push datapath: two data registers, source mux, stack
// pointer with local decrement, address/data registers and the sequencer.
// Assumes a synchronous memory that writes on each clock with mem_we high.
module stack_push_unit #(
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 16,
    parameter int                MEM_CYC  = 2,
    parameter logic [ADDR_W-1:0] SP_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              src_sel,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    output logic              done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] sp_value
);

    logic              capture;
    logic              dec_en;
    logic [DATA_W-1:0] bus_data;
    logic [ADDR_W-1:0] sp;

    push_data_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_data  (ld_data),
        .src_sel  (src_sel),
        .bus_data (bus_data)
    );

    push_stack_ptr #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_en (dec_en),
        .sp     (sp)
    );

    push_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .we      (mem_we),
        .sp_in   (sp),
        .bus_in  (bus_data),
        .mar     (mem_addr),
        .mdr     (mem_wdata)
    );

    push_sequencer #(.MEM_CYC(MEM_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .capture (capture),
        .mem_we  (mem_we),
        .dec_en  (dec_en),
        .done    (done)
    );

    assign sp_value = sp;

    // R4: while writing, the address equals the not-yet-decremented pointer.
    a_r4_addr_is_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp));

    // R5: the pointer never moves while memory is being written.
    a_r5_sp_frozen_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> $stable(sp));

endmodule

// File: tb/stack_push_unit_bench.sv
// Bench for stack_push_unit: table-driven pushes, then directed tests.
module stack_push_unit_bench;

    localparam logic [15:0] SP_TOP = 16'h0005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        src_sel = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [7:0]  ld_data = 8'h00;
    logic        done;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [15:0] sp_value;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] mem [16];

    always #4 clk = ~clk;

    stack_push_unit #(.SP_RESET(SP_TOP)) u_stack_push_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .done(done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sp_value(sp_value)
    );

    // Behavioural synchronous memory, indexed by the low address bits.
    always @(posedge clk) if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;

    // Vector table: {src_sel, value for A, value for B}.
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 8'h3C, 8'hA5}, {1'b1, 8'h01, 8'hFE},
        {1'b0, 8'h80, 8'h7F}, {1'b1, 8'h00, 8'hFF},
        {1'b0, 8'h55, 8'hAA}, {1'b1, 8'h12, 8'h34},
        {1'b0, 8'hC3, 8'h00}, {1'b1, 8'h69, 8'h96}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_reg(input logic which, input logic [7:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = which; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // mode 0: plain; 1: second start during write; 2: load A and flip select mid-push.
    task automatic do_push(input logic sel, input int mode,
                           output int we_cnt, output int done_at, output int done_cnt);
        @(negedge clk);
        start = 1'b1; src_sel = sel;
        @(negedge clk);
        start = 1'b0;
        we_cnt = 0; done_at = 0; done_cnt = 0;
        for (int i = 1; i <= 8; i++) begin
            if (mem_we) we_cnt++;
            if (done) begin
                done_cnt++;
                if (done_at == 0) done_at = i;
            end
            if (mode == 1 && i == 2) start = 1'b1;
            if (mode == 1 && i == 3) start = 1'b0;
            if (mode == 2 && i == 1) begin
                ld_en = 1'b1; ld_sel = 1'b0; ld_data = 8'h99; src_sel = ~sel;
            end
            if (mode == 2 && i == 2) ld_en = 1'b0;
            if (i < 8) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] sp_model;
        int we_c, d_at, d_c;
        logic [7:0] expv;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 sp", 32'(sp_value), 32'(SP_TOP));
        check("R1 done", 32'(done), 0);
        check("R1 we", 32'(mem_we), 0);
        // R1: registers cleared, observed by pushing A
        do_push(1'b0, 0, we_c, d_at, d_c);
        check("R1 A cleared", 32'(mem[SP_TOP[3:0]]), 32'h00);
        sp_model = SP_TOP - 16'd1;

        // Table walk: R2, R3, R4, R5 (including wrap), R6.
        for (int k = 0; k < 8; k++) begin
            load_reg(1'b0, VEC[k][15:8]);
            load_reg(1'b1, VEC[k][7:0]);
            expv = VEC[k][16] ? VEC[k][7:0] : VEC[k][15:8];
            do_push(VEC[k][16], 0, we_c, d_at, d_c);
            check("R2/R4 written byte at SP", 32'(mem[sp_model[3:0]]), 32'(expv));
            check("R3 write cycles", 32'(we_c), 2);
            check("R6 done cycle", 32'(d_at), 4);
            check("R6 done count", 32'(d_c), 1);
            sp_model = sp_model - 16'd1;
            check("R5 sp after push", 32'(sp_value), 32'(sp_model));
        end

        // R5: wrap through zero already crossed; confirm value explicitly.
        check("R5 wrap value", 32'(sp_value), 32'hFFFC);

        // R7: start raised during the write is ignored.
        load_reg(1'b1, 8'h5A);
        do_push(1'b1, 1, we_c, d_at, d_c);
        check("R7 we cycles", 32'(we_c), 2);
        check("R7 done count", 32'(d_c), 1);
        check("R7 byte", 32'(mem[sp_model[3:0]]), 32'h5A);
        sp_model = sp_model - 16'd1;
        check("R7 sp single dec", 32'(sp_value), 32'(sp_model));

        // R8: mid-push load and select flip do not change the written byte.
        load_reg(1'b0, 8'h11);
        load_reg(1'b1, 8'h22);
        do_push(1'b0, 2, we_c, d_at, d_c);
        check("R8 byte unchanged", 32'(mem[sp_model[3:0]]), 32'h11);
        sp_model = sp_model - 16'd1;
        do_push(1'b0, 0, we_c, d_at, d_c);
        check("R8 load effective next push", 32'(mem[sp_model[3:0]]), 32'h99);
        sp_model = sp_model - 16'd1;
        check("R8 sp", 32'(sp_value), 32'(sp_model));

        // R1: reset mid-stream restores the pointer.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 sp after reset", 32'(sp_value), 32'(SP_TOP));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule